// File: doc/BRIEF.md
# Escalating Hang-Recovery Watchdog

This block supervises a host processor by issuing a periodic challenge and expecting a response inside each supervision window. A window that closes without a response is taken as a processor hang. The block then works through a ladder of recovery actions, from mildest to harshest: it pulses a selectable set of interrupt lines, then raises a software-reboot request, then a hardware reset pulse, and finally turns the processor supply off through a power-switch drive output. Each rung has its own wait window. A response that arrives during a window ends the escalation and supervision resumes.

The window length is counted in millisecond ticks from a prescaler, so one 16-bit register covers settings from 1 ms to over a minute. Recovery pulse width is programmable in clock cycles. Sticky status flags record that a hang occurred and which rung brought the processor back, or that a power cycle was needed, so recovery software can pick its restart path after boot. Software clears the flags with write-one-to-clear. An enable input turns supervision on and off, and the synchronous reset returns the block to idle with default settings.

Register map (word addresses): 0 window length in ms ticks, 1 pulse width in clock cycles, 2 interrupt-line select mask, 3 status flags.

Top module: `hang_recovery_wdog`

## Requirements
- R1: While and after reset, chal_o and every recovery output are low, pwr_on_o is high, the status register (address 3) reads 0, and the window register (address 0) reads DEF_TIMEOUT.
- R2: With sup_en high and each challenge answered, chal_o is a one-cycle pulse repeating every TIMEOUT*CLK_PER_MS+1 cycles and no recovery output becomes active.
- R3: When a window closes with no response, the interrupt lines selected by the mask at address 2 rise TIMEOUT*CLK_PER_MS+2 cycles after that window's challenge, and status bit 0 (hang seen) is set.
- R4: Without responses, recovery escalates in the fixed order interrupt, software reboot (swrb_o), hardware reset (hrst_o), power off (pwr_on_o low), each rising PULSE+TIMEOUT*CLK_PER_MS+2 cycles after the previous one.
- R5: Each recovery pulse lasts exactly the number of clock cycles at address 1, and at most one kind of recovery output is active at a time.
- R6: After the power-off pulse, pwr_on_o returns high and responses are ignored until the next challenge, which rises TIMEOUT*CLK_PER_MS+1 cycles later; status bit 4 is set and a later miss starts again at the interrupt rung.
- R7: A response during the pulse or wait window of the interrupt, software-reboot or hardware-reset rung ends the escalation, restarts challenges, and sets status bit 1, 2 or 3 respectively.
- R8: Status flags stay set until a write to address 3 with a 1 in the bit position; bits written 0 are unchanged.
- R9: With sup_en low, chal_o and all recovery outputs stay inactive from the next cycle; raising sup_en restarts supervision with a challenge within two cycles.
- R10: The window register holds values up to 65535 ticks (for example 60000, one minute) and reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to idle and default settings |
| sup_en | input | 1 | Supervision enable |
| resp_i | input | 1 | Processor response pulse |
| chal_o | output | 1 | Challenge pulse to the processor |
| irq_o | output | NUM_IRQ | Interrupt recovery lines |
| swrb_o | output | 1 | Software-reboot request pulse |
| hrst_o | output | 1 | Hardware reset pulse |
| pwr_on_o | output | 1 | Power-switch drive, low turns the supply off |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, one cycle after the address |

## Verification
The main function is driven with three response patterns: every challenge answered, which separates correct window timing from a false hang; no responses at all, which exposes the rung order, spacing, pulse widths and the return to supervision after power-off; and a single late response during the software-reboot rung, which shows that escalation stops at the right rung and records it. Responses injected while the supply is off or during the hold window tell apart a block that ignores them from one that would resume too early. Disabling mid-escalation and resetting mid-escalation show that both return the block to a quiet idle.

// File: rtl/hrw_pkg.sv
package hrw_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_WATCH, PH_PULSE, PH_WAIT, PH_HOLD
  } phase_e;

  localparam int A_TIMEOUT = 0;
  localparam int A_PULSE   = 1;
  localparam int A_IRQSEL  = 2;
  localparam int A_STATUS  = 3;

  localparam int ST_HANG     = 0;
  localparam int ST_REC_IRQ  = 1;
  localparam int ST_REC_SWRB = 2;
  localparam int ST_REC_HRST = 3;
  localparam int ST_PWR      = 4;
  localparam int NST         = 5;

  localparam logic [1:0] RUNG_IRQ  = 2'd0;
  localparam logic [1:0] RUNG_SWRB = 2'd1;
  localparam logic [1:0] RUNG_HRST = 2'd2;
  localparam logic [1:0] RUNG_PWR  = 2'd3;
endpackage

// File: rtl/hrw_tick_timer.sv
module hrw_tick_timer #(
  parameter int CLK_PER_MS = 125000,
  parameter int TICK_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [TICK_W-1:0] limit,
  output logic              done
);
  localparam int PRE_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_MS - 1);

  logic              busy;
  logic [PRE_W-1:0]  pre;
  logic [TICK_W-1:0] ticks;
  logic [TICK_W:0]   lim_eff;

  assign lim_eff = (limit == '0) ? (TICK_W+1)'(1) : {1'b0, limit};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      pre   <= '0;
      ticks <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy  <= 1'b1;
        pre   <= '0;
        ticks <= '0;
      end else if (busy) begin
        if (pre == PRE_LAST) begin
          pre <= '0;
          if ({1'b0, ticks} + (TICK_W+1)'(1) >= lim_eff) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            ticks <= ticks + TICK_W'(1);
          end
        end else begin
          pre <= pre + PRE_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/hrw_pulse_gen.sv
module hrw_pulse_gen #(
  parameter int PW_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [PW_W-1:0] width,
  output logic            active,
  output logic            done
);
  logic [PW_W-1:0] cnt;
  logic [PW_W:0]   w_eff;

  assign w_eff = (width == '0) ? (PW_W+1)'(1) : {1'b0, width};

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (active) begin
        if ({1'b0, cnt} + (PW_W+1)'(1) >= w_eff) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          cnt <= cnt + PW_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/hrw_regs.sv
module hrw_regs
  import hrw_pkg::*;
#(
  parameter int AW          = 2,
  parameter int DW          = 16,
  parameter int TICK_W      = 16,
  parameter int PW_W        = 16,
  parameter int NUM_IRQ     = 8,
  parameter int DEF_TIMEOUT = 1000,
  parameter int DEF_PULSE   = 16,
  parameter int DEF_IRQSEL  = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  input  logic [NST-1:0]     stat_set,
  output logic [DW-1:0]      rdata,
  output logic [TICK_W-1:0]  timeout,
  output logic [PW_W-1:0]    pwidth,
  output logic [NUM_IRQ-1:0] irq_sel,
  output logic [NST-1:0]     status
);
  logic hit_to, hit_pw, hit_sel, hit_st;

  assign hit_to  = (addr == AW'(A_TIMEOUT));
  assign hit_pw  = (addr == AW'(A_PULSE));
  assign hit_sel = (addr == AW'(A_IRQSEL));
  assign hit_st  = (addr == AW'(A_STATUS));

  always_ff @(posedge clk) begin
    if (rst) begin
      timeout <= TICK_W'(DEF_TIMEOUT);
      pwidth  <= PW_W'(DEF_PULSE);
      irq_sel <= NUM_IRQ'(DEF_IRQSEL);
      status  <= '0;
      rdata   <= '0;
    end else begin
      if (we && hit_to)  timeout <= wdata[TICK_W-1:0];
      if (we && hit_pw)  pwidth  <= wdata[PW_W-1:0];
      if (we && hit_sel) irq_sel <= wdata[NUM_IRQ-1:0];
      if (we && hit_st) status <= (status & ~wdata[NST-1:0]) | stat_set;
      else              status <= status | stat_set;
      if (hit_to)       rdata <= DW'(timeout);
      else if (hit_pw)  rdata <= DW'(pwidth);
      else if (hit_sel) rdata <= DW'(irq_sel);
      else if (hit_st)  rdata <= DW'(status);
      else              rdata <= '0;
    end
  end
endmodule

// File: rtl/hang_recovery_wdog.sv
module hang_recovery_wdog
  import hrw_pkg::*;
#(
  parameter int CLK_PER_MS  = 125000,
  parameter int TICK_W      = 16,
  parameter int PW_W        = 16,
  parameter int NUM_IRQ     = 8,
  parameter int AW          = 2,
  parameter int DW          = 16,
  parameter int DEF_TIMEOUT = 1000,
  parameter int DEF_PULSE   = 16,
  parameter int DEF_IRQSEL  = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sup_en,
  input  logic               resp_i,
  output logic               chal_o,
  output logic [NUM_IRQ-1:0] irq_o,
  output logic               swrb_o,
  output logic               hrst_o,
  output logic               pwr_on_o,
  input  logic               reg_we,
  input  logic [AW-1:0]      reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata
);
  phase_e             phase, phase_n;
  logic [1:0]         rung, rung_n;
  logic               got, got_n;
  logic               tmr_go, tmr_done, pls_go, pls_act, pls_done, chal_n;
  logic [NST-1:0]     set_n, status;
  logic [TICK_W-1:0]  timeout;
  logic [PW_W-1:0]    pwidth;
  logic [NUM_IRQ-1:0] irq_sel;
  logic               drive;

  hrw_regs #(
    .AW(AW), .DW(DW), .TICK_W(TICK_W), .PW_W(PW_W), .NUM_IRQ(NUM_IRQ),
    .DEF_TIMEOUT(DEF_TIMEOUT), .DEF_PULSE(DEF_PULSE), .DEF_IRQSEL(DEF_IRQSEL)
  ) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .stat_set(set_n), .rdata(reg_rdata), .timeout(timeout), .pwidth(pwidth),
    .irq_sel(irq_sel), .status(status)
  );

  hrw_tick_timer #(.CLK_PER_MS(CLK_PER_MS), .TICK_W(TICK_W)) u_timer (
    .clk(clk), .rst(rst), .start(tmr_go), .limit(timeout), .done(tmr_done)
  );

  hrw_pulse_gen #(.PW_W(PW_W)) u_pulse (
    .clk(clk), .rst(rst), .start(pls_go), .width(pwidth),
    .active(pls_act), .done(pls_done)
  );

  always_comb begin
    phase_n = phase;
    rung_n  = rung;
    got_n   = got;
    tmr_go  = 1'b0;
    pls_go  = 1'b0;
    chal_n  = 1'b0;
    set_n   = '0;
    if (!sup_en) begin
      phase_n = PH_IDLE;
      rung_n  = RUNG_IRQ;
      got_n   = 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          phase_n = PH_WATCH;
          tmr_go  = 1'b1;
          chal_n  = 1'b1;
          got_n   = 1'b0;
        end
        PH_WATCH: begin
          if (resp_i) got_n = 1'b1;
          if (tmr_done) begin
            got_n = 1'b0;
            if (got || resp_i) begin
              tmr_go = 1'b1;
              chal_n = 1'b1;
            end else begin
              set_n[ST_HANG] = 1'b1;
              rung_n  = RUNG_IRQ;
              phase_n = PH_PULSE;
              pls_go  = 1'b1;
            end
          end
        end
        PH_PULSE: begin
          if (resp_i && rung != RUNG_PWR) begin
            set_n[ST_REC_IRQ + int'(rung)] = 1'b1;
            rung_n  = RUNG_IRQ;
            phase_n = PH_WATCH;
            tmr_go  = 1'b1;
            chal_n  = 1'b1;
          end else if (pls_done) begin
            tmr_go = 1'b1;
            if (rung == RUNG_PWR) begin
              set_n[ST_PWR] = 1'b1;
              phase_n = PH_HOLD;
            end else begin
              phase_n = PH_WAIT;
            end
          end
        end
        PH_WAIT: begin
          if (resp_i) begin
            set_n[ST_REC_IRQ + int'(rung)] = 1'b1;
            rung_n  = RUNG_IRQ;
            phase_n = PH_WATCH;
            tmr_go  = 1'b1;
            chal_n  = 1'b1;
          end else if (tmr_done) begin
            rung_n  = rung + 2'd1;
            phase_n = PH_PULSE;
            pls_go  = 1'b1;
          end
        end
        PH_HOLD: begin
          if (tmr_done) begin
            rung_n  = RUNG_IRQ;
            phase_n = PH_WATCH;
            tmr_go  = 1'b1;
            chal_n  = 1'b1;
          end
        end
        default: phase_n = PH_IDLE;
      endcase
    end
  end

  assign drive = sup_en && (phase == PH_PULSE) && pls_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      rung     <= RUNG_IRQ;
      got      <= 1'b0;
      chal_o   <= 1'b0;
      irq_o    <= '0;
      swrb_o   <= 1'b0;
      hrst_o   <= 1'b0;
      pwr_on_o <= 1'b1;
    end else begin
      phase    <= phase_n;
      rung     <= rung_n;
      got      <= got_n;
      chal_o   <= chal_n;
      irq_o    <= (drive && rung == RUNG_IRQ) ? irq_sel : '0;
      swrb_o   <= drive && (rung == RUNG_SWRB);
      hrst_o   <= drive && (rung == RUNG_HRST);
      pwr_on_o <= !(drive && (rung == RUNG_PWR));
    end
  end
endmodule

// File: rtl/hrw_chk.sv
module hrw_chk #(
  parameter int NUM_IRQ = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               sup_en,
  input logic               chal_o,
  input logic [NUM_IRQ-1:0] irq_o,
  input logic               swrb_o,
  input logic               hrst_o,
  input logic               pwr_on_o
);
  // R5
  rec_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({|irq_o, swrb_o, hrst_o, !pwr_on_o}));

  // R2
  chal_single_chk: assert property (@(posedge clk) disable iff (rst)
    chal_o |=> !chal_o);

  // R6
  pwr_no_chal_chk: assert property (@(posedge clk) disable iff (rst)
    !pwr_on_o |-> !chal_o);

  // R9
  dis_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!sup_en) |-> (!chal_o && irq_o == '0 && !swrb_o && !hrst_o && pwr_on_o));

  // R1
  rst_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (!chal_o && irq_o == '0 && !swrb_o && !hrst_o && pwr_on_o));
endmodule

bind hang_recovery_wdog hrw_chk #(.NUM_IRQ(NUM_IRQ)) i_hrw_chk (
  .clk(clk), .rst(rst), .sup_en(sup_en), .chal_o(chal_o), .irq_o(irq_o),
  .swrb_o(swrb_o), .hrst_o(hrst_o), .pwr_on_o(pwr_on_o)
);

// File: tb/test_hang_recovery_wdog.sv
module test_hang_recovery_wdog;
  localparam int CPM = 4;
  localparam int TO  = 3;
  localparam int PW  = 5;
  localparam int LC  = TO * CPM;
  localparam int DEF_TO = 1000;

  logic clk = 1'b0, rst = 1'b1, sup_en = 1'b0;
  logic resp_auto = 1'b0, resp_man = 1'b0, auto_ack = 1'b0;
  logic resp_i;
  logic chal_o, swrb_o, hrst_o, pwr_on_o, reg_we = 1'b0;
  logic [7:0]  irq_o;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  int cyc = 0, nchk = 0, nfail = 0;
  logic done_flag = 1'b0;

  assign resp_i = resp_auto | resp_man;

  hang_recovery_wdog #(.CLK_PER_MS(CPM), .DEF_TIMEOUT(DEF_TO)) i_hang_recovery_wdog (
    .clk(clk), .rst(rst), .sup_en(sup_en), .resp_i(resp_i), .chal_o(chal_o),
    .irq_o(irq_o), .swrb_o(swrb_o), .hrst_o(hrst_o), .pwr_on_o(pwr_on_o),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) resp_auto <= auto_ack && chal_o;

  always @(posedge clk) if (cyc == 150000 && !done_flag) begin
    nfail++;
    $display("FAIL watchdog: run hung, actual cycles %0d expected fewer", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  function automatic logic sig(input int s);
    case (s)
      0: return chal_o;
      1: return |irq_o;
      2: return swrb_o;
      3: return hrst_o;
      default: return !pwr_on_o;
    endcase
  endfunction

  task automatic wait_edge(input int s, input bit rise, output int t);
    logic prev;
    prev = sig(s);
    t = -1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (sig(s) == rise && prev == !rise) begin t = cyc; break; end
      prev = sig(s);
    end
  endtask

  task automatic reg_write(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input int a, output int d);
    @(negedge clk);
    reg_addr = 2'(a);
    @(negedge clk);
    d = int'(reg_rdata);
  endtask

  task automatic pulse_resp();
    @(negedge clk); resp_man = 1'b1;
    @(negedge clk); resp_man = 1'b0;
  endtask

  task automatic t_reset_state();
    int d;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!chal_o && irq_o == 0 && !swrb_o && !hrst_o, "R1 outputs idle in reset", int'(irq_o), 0);
    chk(pwr_on_o == 1'b1, "R1 power on in reset", int'(pwr_on_o), 1);
    rst = 1'b0;
    reg_read(3, d); chk(d == 0, "R1 status after reset", d, 0);
    reg_read(0, d); chk(d == DEF_TO, "R1 window default", d, DEF_TO);
  endtask

  task automatic t_config();
    int d;
    reg_write(0, 60000); reg_read(0, d);
    chk(d == 60000, "R10 one-minute window readback", d, 60000);
    reg_write(0, TO); reg_write(1, PW); reg_write(2, 'hA4);
    reg_read(1, d); chk(d == PW, "R10 pulse width readback", d, PW);
  endtask

  task automatic t_healthy();
    int ta, tb, bad;
    auto_ack = 1'b1; sup_en = 1'b1;
    wait_edge(0, 1, ta); wait_edge(0, 1, tb);
    chk(tb - ta == LC + 1, "R2 challenge period", tb - ta, LC + 1);
    bad = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (irq_o != 0 || swrb_o || hrst_o || !pwr_on_o) bad++;
    end
    chk(bad == 0, "R2 no recovery while answered", bad, 0);
  endtask

  task automatic t_escalate();
    int t0, t1, t2, t3, t4, t5, tc, d;
    auto_ack = 1'b0;
    repeat (2) @(negedge clk);
    wait_edge(0, 1, t0);
    wait_edge(1, 1, t1);
    chk(t1 - t0 == LC + 2, "R3 interrupt after missed window", t1 - t0, LC + 2);
    chk(irq_o == 8'hA4, "R3 selected interrupt lines", int'(irq_o), 'hA4);
    wait_edge(1, 0, t2);
    chk(t2 - t1 == PW, "R5 interrupt pulse width", t2 - t1, PW);
    wait_edge(2, 1, t2);
    chk(t2 - t1 == PW + LC + 2, "R4 soft reboot follows interrupt", t2 - t1, PW + LC + 2);
    wait_edge(2, 0, t5);
    chk(t5 - t2 == PW, "R5 soft reboot width", t5 - t2, PW);
    wait_edge(3, 1, t3);
    chk(t3 - t2 == PW + LC + 2, "R4 hard reset follows soft reboot", t3 - t2, PW + LC + 2);
    wait_edge(4, 1, t4);
    chk(t4 - t3 == PW + LC + 2, "R4 power off follows hard reset", t4 - t3, PW + LC + 2);
    pulse_resp();
    wait_edge(4, 0, t5);
    chk(t5 - t4 == PW, "R6 supply off width", t5 - t4, PW);
    pulse_resp();
    wait_edge(0, 1, tc);
    chk(tc - t5 == LC + 1, "R6 hold window before next challenge", tc - t5, LC + 1);
    reg_read(3, d);
    chk(d == 'h11, "R6 status hang and power cycle", d, 'h11);
    wait_edge(1, 1, t1);
    chk(t1 - tc == LC + 2, "R6 rung restarts at interrupt", t1 - tc, LC + 2);
    sup_en = 1'b0;
    auto_ack = 1'b1;
  endtask

  task automatic t_w1c();
    int d;
    reg_write(3, 'h01); reg_read(3, d);
    chk(d == 'h10, "R8 clear only bit 0", d, 'h10);
    reg_write(3, 'h10); reg_read(3, d);
    chk(d == 0, "R8 clear bit 4", d, 0);
  endtask

  task automatic t_recover();
    int t, tc, d, bad;
    sup_en = 1'b1; auto_ack = 1'b1;
    wait_edge(0, 1, t);
    auto_ack = 1'b0;
    repeat (2) @(negedge clk);
    wait_edge(2, 1, t);
    pulse_resp();
    auto_ack = 1'b1;
    tc = -1;
    for (int i = 0; i < 3; i++) begin
      if (chal_o) begin tc = i; break; end
      @(negedge clk);
    end
    chk(tc >= 0, "R7 challenge resumes after late response", tc, 0);
    bad = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (hrst_o || !pwr_on_o || swrb_o) bad++;
    end
    chk(bad == 0, "R7 escalation stopped", bad, 0);
    reg_read(3, d);
    chk(d == 'h05, "R7 status records soft reboot rung", d, 'h05);
    reg_write(3, 'h1F);
  endtask

  task automatic t_disable();
    int t, bad;
    auto_ack = 1'b0;
    repeat (2) @(negedge clk);
    wait_edge(1, 1, t);
    sup_en = 1'b0;
    @(negedge clk);
    bad = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (chal_o || irq_o != 0 || swrb_o || hrst_o || !pwr_on_o) bad++;
    end
    chk(bad == 0, "R9 quiet while disabled", bad, 0);
    sup_en = 1'b1;
    t = -1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (chal_o) begin t = i; break; end
    end
    chk(t >= 0, "R9 challenge after enable", t, 1);
  endtask

  task automatic t_ext_reset();
    int t, d;
    wait_edge(1, 1, t);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(irq_o == 0 && !chal_o && pwr_on_o, "R1 reset mid-escalation idles outputs", int'(irq_o), 0);
    reg_read(3, d); chk(d == 0, "R1 reset clears status", d, 0);
    reg_read(0, d); chk(d == DEF_TO, "R1 reset restores window", d, DEF_TO);
  endtask

  initial begin
    t_reset_state();
    t_config();
    t_healthy();
    t_escalate();
    t_w1c();
    t_recover();
    t_disable();
    t_ext_reset();
    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule